// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block turns a 32-bit virtual address into a physical address, one lookup per cycle. Each stored translation carries an 8-bit address-space tag. A per-ring tag register picks the tag that a lookup must match. The ring comes with the request. When an entry is written, its tag is taken from the same register, using the ring that the writer supplies. A tag of zero means the entry is empty. The ring 0 field is fixed at 1.

Two kinds of storage are searched in parallel. The first is a set-associative bank of 4 KB translations. Software fills it, and the bank chooses the way to replace with a round-robin pointer kept for each set. The second is an 8-entry way of 512 MB translations, selected by the top three address bits. After reset it maps the whole 4 GB space one-to-one for tag 1, writable, executable and uncached. Code running in ring 0 therefore has a working address map before any page table exists.

Every lookup produces one registered result. The result is exactly one of three outcomes: a single hit (with the physical address, the cacheable attribute and a protection-fault flag), a miss, or a multi-hit error. Writes take effect on the following cycle.

Top module: `xlat_tlb`

## Requirements
- R1: After reset `rs_valid` is 0. A ring 0 lookup of any address then hits with `rs_pa` equal to the virtual address, `rs_cache` 0, and no fault for write or execute accesses.
- R2: The result of a lookup presented with `lk_valid` high appears one cycle later with `rs_valid` high. A cycle without `lk_valid` gives `rs_valid` low one cycle later.
- R3: An entry matches only when its tag equals the ring's field in the tag register, where ring k uses bits [8k+7:8k] of `map_wdata`. Entries keep their tag when the register changes.
- R4: The ring 0 field always reads as tag 1. A `map_we` write ignores bits [7:0].
- R5: An entry with tag 0 never matches. A write with `wr_inval` high stores tag 0.
- R6: A small-page write goes to set `wr_vpn[1:0]`, in the way named by that set's round-robin pointer. The pointers start at way 0 and advance by one per write to the set, so the fifth write to a set replaces the first.
- R7: A small-page hit gives `{ppn[19:0], va[11:0]}`. A large-page hit gives `{ppn[2:0], va[28:0]}`, and the large entry is chosen by `va[31:29]` (or by `wr_idx` for writes).
- R8: If more than one entry matches, `rs_multi` is 1, while `rs_hit`, `rs_fault` and `rs_pa` are 0.
- R9: A single hit raises `rs_fault` when `lk_write` is set and the entry is not writable, or when `lk_exec` is set and the entry is not executable. `rs_hit` stays 1.
- R10: When no entry matches, `rs_miss` is 1 and `rs_pa` is 0.
- R11: A write (entry or tag register) is seen by lookups from the cycle after its strobe. A lookup in the same cycle sees the old contents.
- R12: `rs_cache` gives the cacheable attribute of the single matching entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address |
| lk_ring | input | 2 | Privilege ring of the access |
| lk_write | input | 1 | Access is a store |
| lk_exec | input | 1 | Access is an instruction fetch |
| wr_en | input | 1 | Entry write strobe |
| wr_big | input | 1 | 1: large-page way, 0: small-page bank |
| wr_idx | input | 3 | Large-page entry index |
| wr_vpn | input | 20 | Small-page virtual page number |
| wr_ppn | input | 20 | Physical page number (low 3 bits for large pages) |
| wr_ring | input | 2 | Ring whose tag is given to the entry |
| wr_inval | input | 1 | Store tag 0 (empty entry) |
| wr_we | input | 1 | Entry writable |
| wr_xe | input | 1 | Entry executable |
| wr_cache | input | 1 | Entry cacheable |
| map_we | input | 1 | Tag register write strobe |
| map_wdata | input | 32 | Tag per ring, 8 bits each |
| rs_valid | output | 1 | Result valid |
| rs_hit | output | 1 | Exactly one entry matched |
| rs_miss | output | 1 | No entry matched |
| rs_multi | output | 1 | More than one entry matched |
| rs_fault | output | 1 | Protection fault on a hit |
| rs_pa | output | 32 | Physical address |
| rs_cache | output | 1 | Cacheable attribute |

## Verification
Each result is due exactly one clock edge after its request. The bench drives a request on a falling edge, drops it on the next falling edge, and reads every result output at that second falling edge, half a cycle after the registering edge. A write issued on a falling edge is checked by a lookup driven on the next falling edge. The same-cycle case (R11) puts the write and the lookup on the same falling edge and expects the old result. The round-robin order and the expected physical addresses are computed arithmetically from the fill index.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int TLB_VA_W   = 32;
  localparam int TLB_PAGE_W = 12;
  localparam int TLB_VPN_W  = TLB_VA_W - TLB_PAGE_W;
  localparam int TLB_ASID_W = 8;
  localparam int TLB_RINGS  = 4;
  localparam int TLB_BIG_W  = 3;

  typedef struct packed {
    logic we;
    logic xe;
    logic cache;
  } tlb_perm_t;
endpackage

// File: rtl/tlb_asid_map.sv
module tlb_asid_map #(
  parameter int RINGS  = tlb_pkg::TLB_RINGS,
  parameter int ASID_W = tlb_pkg::TLB_ASID_W,
  localparam int RING_W = $clog2(RINGS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [RINGS*ASID_W-1:0] wdata,
  input  logic [RING_W-1:0]       look_ring,
  input  logic [RING_W-1:0]       fill_ring,
  output logic [ASID_W-1:0]       look_asid,
  output logic [ASID_W-1:0]       fill_asid
);
  localparam logic [ASID_W-1:0] KERNEL_ASID = ASID_W'(1);

  logic [ASID_W-1:0] map_q [RINGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < RINGS; k++)
        map_q[k] <= (k == 0) ? KERNEL_ASID : '0;
    end else if (we) begin
      for (int k = 0; k < RINGS; k++)
        map_q[k] <= (k == 0) ? KERNEL_ASID : wdata[k*ASID_W +: ASID_W];
    end
  end

  assign look_asid = map_q[look_ring];
  assign fill_asid = map_q[fill_ring];

  AST_RING0_FIXED: assert property (@(posedge clk) disable iff (rst)
    (look_ring == '0) |-> (look_asid == KERNEL_ASID)); // R4
endmodule

// File: rtl/tlb_auto_bank.sv
module tlb_auto_bank #(
  parameter int WAYS   = 4,
  parameter int SET_W  = 2,
  parameter int VPN_W  = tlb_pkg::TLB_VPN_W,
  parameter int ASID_W = tlb_pkg::TLB_ASID_W,
  localparam int SETS  = 1 << SET_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [VPN_W-1:0]  fill_ppn,
  input  logic [ASID_W-1:0] fill_asid,
  input  tlb_pkg::tlb_perm_t fill_perm,
  input  logic [VPN_W-1:0]  look_vpn,
  input  logic [ASID_W-1:0] look_asid,
  output logic [WAYS-1:0]   match,
  output logic [VPN_W-1:0]  ppn_out,
  output tlb_pkg::tlb_perm_t perm_out
);
  logic [ASID_W-1:0]  tag_asid [WAYS][SETS];
  logic [VPN_W-1:0]   tag_vpn  [WAYS][SETS];
  logic [VPN_W-1:0]   dat_ppn  [WAYS][SETS];
  tlb_pkg::tlb_perm_t dat_perm [WAYS][SETS];
  logic [WAY_W-1:0]   rr_q [SETS];

  logic [SET_W-1:0] fill_set, look_set;
  assign fill_set = fill_vpn[SET_W-1:0];
  assign look_set = look_vpn[SET_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        rr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) tag_asid[w][s] <= '0;
      end
    end else if (fill_en) begin
      rr_q[fill_set] <= rr_q[fill_set] + 1'b1;
      tag_asid[rr_q[fill_set]][fill_set] <= fill_asid;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_vpn[rr_q[fill_set]][fill_set]  <= fill_vpn;
      dat_ppn[rr_q[fill_set]][fill_set]  <= fill_ppn;
      dat_perm[rr_q[fill_set]][fill_set] <= fill_perm;
    end
  end

  logic [ASID_W-1:0] way_asid [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_asid[w] = tag_asid[w][look_set];
    assign match[w] = (way_asid[w] != '0) && (way_asid[w] == look_asid)
                      && (tag_vpn[w][look_set] == look_vpn);

    AST_EMPTY_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
      (way_asid[w] == '0) |-> !match[w]); // R5
  end

  always_comb begin
    ppn_out  = '0;
    perm_out = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) begin
        ppn_out  = ppn_out | dat_ppn[w][look_set];
        perm_out = perm_out | dat_perm[w][look_set];
      end
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_rr
    AST_RR_STEP: assert property (@(posedge clk) disable iff (rst)
      (fill_en && fill_set == SET_W'(s)) |=> (rr_q[s] == $past(rr_q[s]) + 1'b1)); // R6
  end
endmodule

// File: rtl/tlb_big_way.sv
module tlb_big_way #(
  parameter int IDX_W  = tlb_pkg::TLB_BIG_W,
  parameter int ASID_W = tlb_pkg::TLB_ASID_W,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [IDX_W-1:0]  fill_ppn,
  input  logic [ASID_W-1:0] fill_asid,
  input  tlb_pkg::tlb_perm_t fill_perm,
  input  logic [IDX_W-1:0]  look_idx,
  input  logic [ASID_W-1:0] look_asid,
  output logic              match,
  output logic [IDX_W-1:0]  ppn_out,
  output tlb_pkg::tlb_perm_t perm_out
);
  logic [ASID_W-1:0]  ent_asid [ENTRIES];
  logic [IDX_W-1:0]   ent_ppn  [ENTRIES];
  tlb_pkg::tlb_perm_t ent_perm [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ent_asid[i] <= ASID_W'(1);
        ent_ppn[i]  <= IDX_W'(i);
        ent_perm[i] <= '{we: 1'b1, xe: 1'b1, cache: 1'b0};
      end
    end else if (fill_en) begin
      ent_asid[fill_idx] <= fill_asid;
      ent_ppn[fill_idx]  <= fill_ppn;
      ent_perm[fill_idx] <= fill_perm;
    end
  end

  assign match    = (ent_asid[look_idx] != '0) && (ent_asid[look_idx] == look_asid);
  assign ppn_out  = ent_ppn[look_idx];
  assign perm_out = ent_perm[look_idx];
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int WAYS   = 4,
  parameter int SET_W  = 2,
  parameter int VA_W   = tlb_pkg::TLB_VA_W,
  parameter int PAGE_W = tlb_pkg::TLB_PAGE_W,
  parameter int ASID_W = tlb_pkg::TLB_ASID_W,
  parameter int RINGS  = tlb_pkg::TLB_RINGS,
  parameter int BIG_W  = tlb_pkg::TLB_BIG_W,
  localparam int VPN_W  = VA_W - PAGE_W,
  localparam int RING_W = $clog2(RINGS),
  localparam int BOFF_W = VA_W - BIG_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lk_valid,
  input  logic [VA_W-1:0]         lk_va,
  input  logic [RING_W-1:0]       lk_ring,
  input  logic                    lk_write,
  input  logic                    lk_exec,
  input  logic                    wr_en,
  input  logic                    wr_big,
  input  logic [BIG_W-1:0]        wr_idx,
  input  logic [VPN_W-1:0]        wr_vpn,
  input  logic [VPN_W-1:0]        wr_ppn,
  input  logic [RING_W-1:0]       wr_ring,
  input  logic                    wr_inval,
  input  logic                    wr_we,
  input  logic                    wr_xe,
  input  logic                    wr_cache,
  input  logic                    map_we,
  input  logic [RINGS*ASID_W-1:0] map_wdata,
  output logic                    rs_valid,
  output logic                    rs_hit,
  output logic                    rs_miss,
  output logic                    rs_multi,
  output logic                    rs_fault,
  output logic [VA_W-1:0]         rs_pa,
  output logic                    rs_cache
);
  logic [ASID_W-1:0] look_asid, map_fill_asid, fill_asid;
  tlb_pkg::tlb_perm_t fill_perm, auto_perm, big_perm, sel_perm;
  logic [WAYS-1:0]  auto_match;
  logic [VPN_W-1:0] auto_ppn;
  logic             big_match;
  logic [BIG_W-1:0] big_ppn;

  assign fill_asid = wr_inval ? '0 : map_fill_asid;
  assign fill_perm = '{we: wr_we, xe: wr_xe, cache: wr_cache};

  tlb_asid_map #(.RINGS(RINGS), .ASID_W(ASID_W)) i_map (
    .clk(clk), .rst(rst), .we(map_we), .wdata(map_wdata),
    .look_ring(lk_ring), .fill_ring(wr_ring),
    .look_asid(look_asid), .fill_asid(map_fill_asid)
  );

  tlb_auto_bank #(.WAYS(WAYS), .SET_W(SET_W), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_bank (
    .clk(clk), .rst(rst), .fill_en(wr_en && !wr_big),
    .fill_vpn(wr_vpn), .fill_ppn(wr_ppn), .fill_asid(fill_asid), .fill_perm(fill_perm),
    .look_vpn(lk_va[VA_W-1:PAGE_W]), .look_asid(look_asid),
    .match(auto_match), .ppn_out(auto_ppn), .perm_out(auto_perm)
  );

  tlb_big_way #(.IDX_W(BIG_W), .ASID_W(ASID_W)) i_big (
    .clk(clk), .rst(rst), .fill_en(wr_en && wr_big),
    .fill_idx(wr_idx), .fill_ppn(wr_ppn[BIG_W-1:0]), .fill_asid(fill_asid),
    .fill_perm(fill_perm), .look_idx(lk_va[VA_W-1:BOFF_W]), .look_asid(look_asid),
    .match(big_match), .ppn_out(big_ppn), .perm_out(big_perm)
  );

  logic [$clog2(WAYS+2)-1:0] n_match;
  logic                      one_hit, many_hit, no_hit, fault_c;
  logic [VA_W-1:0]           pa_c;

  always_comb begin
    n_match  = $bits(n_match)'($countones({big_match, auto_match}));
    one_hit  = (n_match == 1);
    many_hit = (n_match > 1);
    no_hit   = (n_match == 0);
    sel_perm = big_match ? big_perm : auto_perm;
    pa_c     = '0;
    if (one_hit)
      pa_c = big_match ? {big_ppn, lk_va[BOFF_W-1:0]} : {auto_ppn, lk_va[PAGE_W-1:0]};
    fault_c  = one_hit && ((lk_write && !sel_perm.we) || (lk_exec && !sel_perm.xe));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_miss  <= 1'b0;
      rs_multi <= 1'b0;
      rs_fault <= 1'b0;
      rs_pa    <= '0;
      rs_cache <= 1'b0;
    end else begin
      rs_valid <= lk_valid;
      rs_hit   <= lk_valid && one_hit;
      rs_miss  <= lk_valid && no_hit;
      rs_multi <= lk_valid && many_hit;
      rs_fault <= lk_valid && fault_c;
      rs_pa    <= lk_valid ? pa_c : '0;
      rs_cache <= lk_valid && one_hit && sel_perm.cache;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    rs_valid |-> ($countones({rs_hit, rs_miss, rs_multi}) == 1)); // R8
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rs_valid); // R2
  AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rs_valid); // R2
  AST_MULTI_QUIET: assert property (@(posedge clk) disable iff (rst)
    rs_multi |-> (!rs_hit && !rs_fault && rs_pa == '0)); // R8
  AST_FAULT_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    rs_fault |-> rs_hit); // R9
  AST_MISS_NO_PA: assert property (@(posedge clk) disable iff (rst)
    rs_miss |-> (rs_pa == '0 && !rs_cache)); // R10
endmodule

// File: tb/test_xlat_tlb.sv
module test_xlat_tlb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 0, lk_write = 0, lk_exec = 0;
  logic [31:0] lk_va = '0;
  logic [1:0]  lk_ring = '0;
  logic        wr_en = 0, wr_big = 0, wr_inval = 0, wr_we = 0, wr_xe = 0, wr_cache = 0;
  logic [2:0]  wr_idx = '0;
  logic [19:0] wr_vpn = '0, wr_ppn = '0;
  logic [1:0]  wr_ring = '0;
  logic        map_we = 0;
  logic [31:0] map_wdata = '0;
  logic        rs_valid, rs_hit, rs_miss, rs_multi, rs_fault, rs_cache;
  logic [31:0] rs_pa;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xlat_tlb i_xlat_tlb (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va), .lk_ring(lk_ring),
    .lk_write(lk_write), .lk_exec(lk_exec), .wr_en(wr_en), .wr_big(wr_big),
    .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_ring(wr_ring),
    .wr_inval(wr_inval), .wr_we(wr_we), .wr_xe(wr_xe), .wr_cache(wr_cache),
    .map_we(map_we), .map_wdata(map_wdata), .rs_valid(rs_valid), .rs_hit(rs_hit),
    .rs_miss(rs_miss), .rs_multi(rs_multi), .rs_fault(rs_fault), .rs_pa(rs_pa),
    .rs_cache(rs_cache)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // outcome packed as {valid, hit, miss, multi, fault, cache}
  task automatic expect_res(input string req, input logic [5:0] flags, input logic [31:0] pa);
    check({req, " flags"}, {26'd0, rs_valid, rs_hit, rs_miss, rs_multi, rs_fault, rs_cache},
          {26'd0, flags});
    check({req, " pa"}, rs_pa, pa);
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] ring,
                      input logic wr, input logic ex);
    @(negedge clk);
    lk_valid = 1; lk_va = va; lk_ring = ring; lk_write = wr; lk_exec = ex;
    @(negedge clk);
    lk_valid = 0; lk_write = 0; lk_exec = 0;
  endtask

  task automatic put(input logic big, input logic [2:0] idx, input logic [19:0] vpn,
                     input logic [19:0] ppn, input logic [1:0] ring, input logic inval,
                     input logic we, input logic xe, input logic ca);
    @(negedge clk);
    wr_en = 1; wr_big = big; wr_idx = idx; wr_vpn = vpn; wr_ppn = ppn; wr_ring = ring;
    wr_inval = inval; wr_we = we; wr_xe = xe; wr_cache = ca;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_map(input logic [31:0] v);
    @(negedge clk);
    map_we = 1; map_wdata = v;
    @(negedge clk);
    map_we = 0;
  endtask

  function automatic logic [19:0] auto_ppn(input logic [19:0] vpn);
    return vpn ^ 20'h0F0F0;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] va;
    logic [19:0] vpn;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, rs_valid}, 32'd0);
    rst = 0;

    // R1 R7: identity map in ring 0 over all eight large regions
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < 3; k++) begin
        va = {r[2:0], (k == 0) ? 29'd0 : (k == 1) ? 29'h1FFF_FFFF : 29'h0ABC_D123};
        look(va, 2'd0, k[0], k[1]);
        expect_res("R1 R7 reset identity", 6'b110000, va);
      end
    end
    // R2: idle cycle gives no result
    @(negedge clk);
    check("R2 idle result", {31'd0, rs_valid}, 32'd0);

    // R3: ring 1 tag is 0 at reset, so no match
    look(32'h2000_0000, 2'd1, 0, 0);
    expect_res("R3 ring1 miss", 6'b101000, 32'd0);
    // ring3=0x20, ring2=0, ring1=1, ring0 field written as 0x55 (R4 ignores it)
    set_map(32'h2000_0155);
    look(32'h2000_0004, 2'd1, 0, 0);
    expect_res("R3 ring1 hits tag 1", 6'b110000, 32'h2000_0004);
    look(32'hE000_0008, 2'd0, 0, 0);
    expect_res("R4 ring0 stays tag 1", 6'b110000, 32'hE000_0008);

    // R6 R7 R12: fill 16 small pages for ring 3, round robin per set
    for (int i = 0; i < 16; i++) begin
      vpn = 20'h40000 + 20'(i);
      put(0, 3'd0, vpn, auto_ppn(vpn), 2'd3, 0, i[2], !i[3], i[0]);
    end
    for (int i = 0; i < 16; i++) begin
      vpn = 20'h40000 + 20'(i);
      look({vpn, 12'h5A4}, 2'd3, 1, 1);
      // R9: fault when store to non-writable or fetch from non-executable
      expect_res("R6 R9 R12 small hit",
                 {2'b11, 2'b00, (!i[2]) || i[3], i[0]}, {auto_ppn(vpn), 12'h5A4});
    end
    // R6: fifth write to each set replaces the first
    for (int s = 0; s < 4; s++) put(0, 3'd0, 20'h50000 + 20'(s), auto_ppn(20'h50000 + 20'(s)),
                                     2'd3, 0, 1, 1, 0);
    for (int s = 0; s < 4; s++) begin
      look({20'h40000 + 20'(s), 12'h010}, 2'd3, 0, 0);
      expect_res("R6 replaced entry misses", 6'b101000, 32'd0);
      look({20'h50000 + 20'(s), 12'h020}, 2'd3, 0, 0);
      expect_res("R6 new entry hits", 6'b110000, {auto_ppn(20'h50000 + 20'(s)), 12'h020});
      look({20'h4000C + 20'(s), 12'h030}, 2'd3, 0, 0);
      expect_res("R6 other way kept", {4'b1100, 1'b0, s[0]}, {auto_ppn(20'h4000C + 20'(s)), 12'h030});
    end

    // R3: changing ring 3 tag hides its entries
    set_map(32'h2100_0100);
    look(32'h4000_D000, 2'd3, 0, 0);
    expect_res("R3 retagged ring misses", 6'b101000, 32'd0);
    set_map(32'h2000_0100);
    look(32'h4000_D000, 2'd3, 0, 0);
    expect_res("R3 tag restored hits", {4'b1100, 2'b01}, {auto_ppn(20'h4000D), 12'h000});

    // R5: ring 2 has tag 0, so its entry is empty
    put(0, 3'd0, 20'h60000, 20'h11111, 2'd2, 0, 1, 1, 0);
    look(32'h6000_0000, 2'd2, 0, 0);
    expect_res("R5 tag zero entry", 6'b101000, 32'd0);

    // R8: ring 0 small page overlapping the reset large page
    put(0, 3'd0, 20'h00010, 20'h12345, 2'd0, 0, 1, 1, 1);
    look(32'h0001_0ABC, 2'd0, 1, 0);
    expect_res("R8 multi hit", 6'b100100, 32'd0);
    // R5: invalidate large entry 0, small page now alone
    put(1, 3'd0, 20'd0, 20'd0, 2'd0, 1, 1, 1, 0);
    look(32'h0001_0ABC, 2'd0, 0, 0);
    expect_res("R5 after invalidate", 6'b110001, 32'h1234_5ABC);
    look(32'h0800_0000, 2'd0, 0, 0);
    expect_res("R10 region 0 miss", 6'b101000, 32'd0);

    // R11: write and lookup in the same cycle
    @(negedge clk);
    wr_en = 1; wr_big = 1; wr_idx = 3'd0; wr_ppn = 20'd3; wr_ring = 2'd0; wr_inval = 0;
    wr_we = 1; wr_xe = 1; wr_cache = 0;
    lk_valid = 1; lk_va = 32'h0800_0000; lk_ring = 2'd0;
    @(negedge clk);
    wr_en = 0; lk_valid = 0;
    expect_res("R11 same cycle sees old", 6'b101000, 32'd0);
    look(32'h0800_0000, 2'd0, 0, 0);
    expect_res("R11 R7 next cycle sees new", 6'b110000, 32'h6800_0000);

    // R9 R12: read-only cacheable large page
    put(1, 3'd5, 20'd0, 20'd6, 2'd0, 0, 0, 1, 1);
    look(32'hA123_4567, 2'd0, 1, 0);
    expect_res("R9 R12 store fault", 6'b110011, 32'hC123_4567);
    look(32'hA123_4567, 2'd0, 0, 1);
    expect_res("R9 R12 fetch ok", 6'b110001, 32'hC123_4567);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule